// File: doc/BRIEF.md
# Dual-Axis Quadrature Position Counter

This block tracks the position of two incremental encoders, one per axis. Each axis supplies two square-wave phases that are 90 degrees apart. The block brings every phase into the clock domain and classifies each new pair of samples as a forward step, a reverse step, no movement or an illegal jump. It keeps a wrapping up/down position count for each axis. Every edge of either phase is one count, so one full encoder cycle moves the count by four.

Each axis has its own clear input, and the two axes never affect each other. A one-cycle event strobe rises whenever either position count takes a step. Logic further on can use the strobe to raise a host notification flag without comparing the counts itself. The phase inputs are taken to be clean digital levels that are low while the block-wide reset is applied.

Top module: `dual_quad_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counts become 0x000 and `count_evt` becomes 0.
- R2: With phase pair {A,B} moving through 00, 10, 11, 01, 00 (A leading B), each transition adds one to that axis count.
- R3: With the pair moving through 00, 01, 11, 10, 00 (B leading A), each transition subtracts one from that axis count.
- R4: Rising and falling edges of both phases all count, so one full four-state cycle changes the count by exactly four.
- R5: Counting up from 0xFFF gives 0x000, and counting down from 0x000 gives 0xFFF.
- R6: Steps on one axis never change the other axis count, and the two axes may step in the same cycle.
- R7: A high level on `clr_x` (or `clr_y`) at a rising edge sets only that axis count to 0x000. It wins over a step that falls due at the same edge, and it raises no event for that axis.
- R8: A transition in which both phases of an axis change between consecutive synchronised samples leaves the count unchanged and raises no event.
- R9: `count_evt` is high for exactly the one cycle in which a stepped count value is first visible on the outputs.
- R10: A phase change applied before rising edge k appears on the count output just after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| x_a | input | 1 | X axis phase A |
| x_b | input | 1 | X axis phase B |
| y_a | input | 1 | Y axis phase A |
| y_b | input | 1 | Y axis phase B |
| clr_x | input | 1 | Synchronous active-high clear of the X count |
| clr_y | input | 1 | Synchronous active-high clear of the Y count |
| x_count | output | CNT_W (12) | X axis position count |
| y_count | output | CNT_W (12) | Y axis position count |
| count_evt | output | 1 | One-cycle strobe on any counting step |

## Verification
A phase change passes through two synchroniser flops and is then compared with the previous sample. The count therefore moves at the third rising edge after the change, and `count_evt` rises at that same edge. A clear acts at the first edge where it is high. Inputs are driven on falling edges. Each directed check is taken at the falling edge after the edge where its result is due. The latency check samples once before that edge to confirm the count has not yet moved. A behavioural model keeps its own history of the sampled inputs and predicts both counts and the strobe. It is compared with the outputs at every falling edge.

// File: rtl/quad_pkg.sv
// Shared types and the step classifier for the quadrature counter.
// Assumes the phase pair is packed as {A, B}.
package quad_pkg;

    // Result of comparing two consecutive synchronised phase samples.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_SKIP = 2'd3
    } step_t;

    // Classifies a move from prv to cur; a two-bit jump is illegal.
    function automatic step_t classify_step(input logic [1:0] prv, input logic [1:0] cur);
        logic [1:0] diff;
        diff = prv ^ cur;
        if (diff == 2'b00)
            return STEP_HOLD;
        else if (diff == 2'b11)
            return STEP_SKIP;
        else if (cur[1] ^ prv[0])
            return STEP_INC;
        else
            return STEP_DEC;
    endfunction

endpackage

// File: rtl/quad_sync.sv
// Multi-stage synchroniser for a bus of independent single-bit signals.
// Assumes every bit is asynchronous and treated alone (no bus coherency).
module quad_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q[0] <= '0;
        else
            stage_q[0] <= din;
    end

    // Remaining stages form the settling chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[s] <= '0;
            else
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/quad_phase_decoder.sv
// Compares each synchronised phase pair with the previous one and reports
// whether the axis moved forward, backward, not at all, or jumped illegally.
// Assumes phase is already synchronised to clk.
module quad_phase_decoder
    import quad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase,
    output step_t      step
);

    logic [1:0] prev_q;

    // Holds the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 2'b00;
        else
            prev_q <= phase;
    end

    // Direction discrimination from the previous and current samples.
    always_comb begin
        step = classify_step(prev_q, phase);
    end

endmodule

// File: rtl/quad_axis_counter.sv
// Wrapping up/down position counter for one axis with a synchronous clear.
// Assumes step is valid for one cycle per detected edge; clear wins.
module quad_axis_counter
    import quad_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  step_t            step,
    output logic [CNT_W-1:0] count,
    output logic             stepped
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Updates the count and flags whether it stepped this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            stepped <= 1'b0;
        end else if (clr) begin
            count   <= '0;
            stepped <= 1'b0;
        end else begin
            unique case (step)
                STEP_INC: begin
                    count   <= count + ONE;
                    stepped <= 1'b1;
                end
                STEP_DEC: begin
                    count   <= count - ONE;
                    stepped <= 1'b1;
                end
                default: begin
                    stepped <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dual_quad_counter.sv
// Two-axis quadrature position counter: synchronises both phase pairs,
// decodes direction per axis, counts with per-axis clears and merges the
// step flags into one event strobe.
// Assumes phases are clean levels and low while rst_n is applied.
module dual_quad_counter
    import quad_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_a,
    input  logic             x_b,
    input  logic             y_a,
    input  logic             y_b,
    input  logic             clr_x,
    input  logic             clr_y,
    output logic [CNT_W-1:0] x_count,
    output logic [CNT_W-1:0] y_count,
    output logic             count_evt
);

    localparam int NUM_AXES = 2;
    localparam int PH_W     = 2 * NUM_AXES;

    logic [PH_W-1:0]     raw_ph;
    logic [PH_W-1:0]     sync_ph;
    logic [NUM_AXES-1:0] axis_clr;
    logic [NUM_AXES-1:0] axis_stepped;
    logic [CNT_W-1:0]    axis_count [NUM_AXES];

    // Axis 0 is X, axis 1 is Y; each pair packed as {A, B}.
    assign raw_ph   = {y_a, y_b, x_a, x_b};
    assign axis_clr = {clr_y, clr_x};

    quad_sync #(
        .WIDTH  (PH_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_ph),
        .dout (sync_ph)
    );

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
        step_t step;

        quad_phase_decoder i_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .phase(sync_ph[2*ax +: 2]),
            .step (step)
        );

        quad_axis_counter #(
            .CNT_W(CNT_W)
        ) i_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (axis_clr[ax]),
            .step   (step),
            .count  (axis_count[ax]),
            .stepped(axis_stepped[ax])
        );
    end

    assign x_count   = axis_count[0];
    assign y_count   = axis_count[1];
    assign count_evt = |axis_stepped;

endmodule

// File: rtl/dual_quad_counter_checker.sv
// Assertion checker for dual_quad_counter, attached with bind.
module dual_quad_counter_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_x,
    input logic             clr_y,
    input logic [CNT_W-1:0] x_count,
    input logic [CNT_W-1:0] y_count,
    input logic             count_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (x_count == '0 && y_count == '0 && !count_evt)); // R1

    AST_X_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_x |=> (x_count == $past(x_count) || x_count == $past(x_count) + ONE
                    || x_count == $past(x_count) - ONE)); // R4

    AST_Y_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_y |=> (y_count == $past(y_count) || y_count == $past(y_count) + ONE
                    || y_count == $past(y_count) - ONE)); // R6

    AST_CLEAR_X: assert property (@(posedge clk) disable iff (!rst_n)
        clr_x |=> x_count == '0); // R7

    AST_CLEAR_Y: assert property (@(posedge clk) disable iff (!rst_n)
        clr_y |=> y_count == '0); // R7

    AST_EVT_HAS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_evt |-> (x_count != $past(x_count) || y_count != $past(y_count))); // R9

    AST_CHANGE_HAS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        ((!$past(clr_x) && x_count != $past(x_count))
         || (!$past(clr_y) && y_count != $past(y_count))) |-> count_evt); // R9

endmodule

bind dual_quad_counter dual_quad_counter_checker #(
    .CNT_W(CNT_W)
) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_x    (clr_x),
    .clr_y    (clr_y),
    .x_count  (x_count),
    .y_count  (y_count),
    .count_evt(count_evt)
);

// File: tb/test_dual_quad_counter.sv
module test_dual_quad_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_a = 1'b0, x_b = 1'b0, y_a = 1'b0, y_b = 1'b0;
    logic        clr_x = 1'b0, clr_y = 1'b0;
    logic [11:0] x_count, y_count;
    logic        count_evt;

    int checks = 0;
    int fails  = 0;
    int xi = 0;
    int yi = 0;

    always #5 clk = ~clk;

    dual_quad_counter i_dual_quad_counter (
        .clk(clk), .rst_n(rst_n),
        .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b),
        .clr_x(clr_x), .clr_y(clr_y),
        .x_count(x_count), .y_count(y_count), .count_evt(count_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // {A,B} for a position around the forward cycle.
    function automatic logic [1:0] gray(input int i);
        case (((i % 4) + 4) % 4)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int pos_of(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [1:0] hx[$] = '{2'b00, 2'b00, 2'b00, 2'b00};
    logic [1:0] hy[$] = '{2'b00, 2'b00, 2'b00, 2'b00};
    int mx = 0, my = 0;
    bit mevt = 1'b0;
    bit model_on = 1'b0;

    function automatic int delta(input logic [1:0] prv, input logic [1:0] cur);
        int d;
        d = (pos_of(cur) - pos_of(prv) + 4) % 4;
        if (d == 1) return 1;
        if (d == 3) return -1;
        return 0;
    endfunction

    always @(posedge clk) begin
        int dx, dy;
        hx.push_front(rst_n ? {x_a, x_b} : 2'b00);
        hy.push_front(rst_n ? {y_a, y_b} : 2'b00);
        if (hx.size() > 4) void'(hx.pop_back());
        if (hy.size() > 4) void'(hy.pop_back());
        if (!rst_n) begin
            mx = 0; my = 0; mevt = 1'b0;
        end else begin
            dx = delta(hx[3], hx[2]);
            dy = delta(hy[3], hy[2]);
            mevt = 1'b0;
            if (clr_x) mx = 0;
            else if (dx != 0) begin mx = (mx + dx + 4096) % 4096; mevt = 1'b1; end
            if (clr_y) my = 0;
            else if (dy != 0) begin my = (my + dy + 4096) % 4096; mevt = 1'b1; end
        end
    end

    // Per-cycle comparison with the model (R10 timing, all behaviour).
    always @(negedge clk) begin
        if (model_on) begin
            chk("R10 model x_count", x_count, mx);
            chk("R10 model y_count", y_count, my);
            chk("R10 model count_evt", count_evt, mevt);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive_x(); {x_a, x_b} = gray(xi); endtask
    task automatic drive_y(); {y_a, y_b} = gray(yi); endtask

    task automatic move_x(input int dir, input int n);
        repeat (n) begin
            @(negedge clk); xi += dir; drive_x();
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic move_y(input int dir, input int n);
        repeat (n) begin
            @(negedge clk); yi += dir; drive_y();
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic move_both(input int dx, input int dy, input int n);
        repeat (n) begin
            @(negedge clk); xi += dx; yi += dy; drive_x(); drive_y();
            repeat (3) @(negedge clk);
        end
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        chk("R1 x_count in reset", x_count, 0);
        chk("R1 y_count in reset", y_count, 0);
        chk("R1 count_evt in reset", count_evt, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R4: one full forward cycle gives four counts.
        move_x(1, 4);
        chk("R2 R4 x after forward cycle", x_count, 4);

        // R10 / R9: latency of one step and event pulse width.
        @(negedge clk); xi += 1; drive_x();
        @(posedge clk); @(posedge clk); #1;
        chk("R10 x not yet moved after two edges", x_count, 4);
        @(posedge clk); #1;
        chk("R10 x moved at third edge", x_count, 5);
        chk("R9 event with new count", count_evt, 1);
        @(posedge clk); #1;
        chk("R9 event lasts one cycle", count_evt, 0);

        // R3 / R5: reverse through zero wraps to 0xFFF.
        move_x(-1, 6);
        chk("R3 R5 x after reverse through zero", x_count, 12'hFFF);
        move_x(1, 1);
        chk("R5 x wraps up to zero", x_count, 0);

        // R6: Y alone, then both together.
        move_y(-1, 3);
        chk("R6 y after reverse", y_count, 12'hFFD);
        chk("R6 x untouched by y", x_count, 0);
        move_both(1, -1, 4);
        chk("R6 x with simultaneous steps", x_count, 4);
        chk("R6 y with simultaneous steps", y_count, 12'hFF9);

        // R8: both X phases flip at once (00 -> 11).
        @(negedge clk); xi += 2; drive_x();
        seen = 1'b0;
        repeat (5) begin @(negedge clk); if (count_evt) seen = 1'b1; end
        chk("R8 x unchanged after illegal jump", x_count, 4);
        chk("R8 no event after illegal jump", seen, 0);

        // R7: clear coincides with a due step; clear wins.
        @(negedge clk); xi += 1; drive_x();
        @(negedge clk); @(negedge clk); clr_x = 1'b1;
        @(negedge clk); clr_x = 1'b0;
        chk("R7 x cleared despite due step", x_count, 0);
        chk("R7 no event from clear", count_evt, 0);
        chk("R7 y untouched by clr_x", y_count, 12'hFF9);

        // R7: clear Y only.
        move_x(1, 2);
        @(negedge clk); clr_y = 1'b1;
        @(negedge clk); clr_y = 1'b0;
        chk("R7 y cleared", y_count, 0);
        chk("R7 x untouched by clr_y", x_count, 2);

        repeat (4) @(negedge clk);
        model_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule